// File: doc/BRIEF.md
# Privilege Mode Trap Entry Unit

This unit owns the processor's privilege bit and the program counter and stack pointer registers. Each control transfer between user code and the kernel happens in a single clock edge. When a system call, an external interrupt or a synchronous exception is taken, the unit copies the current program counter, stack pointer and privilege bit into shadow registers. It then loads the kernel stack pointer, enters kernel mode and jumps to a fixed vector. A system call uses its own vector. Interrupts and exceptions share a second vector and also write a cause code. A return-from-trap command reloads all three saved values at once.

When no event is pending, the program counter follows the fetch stage's next-PC whenever an instruction retires, and the stack pointer takes datapath writes. A system call saves the address of the following instruction, so that execution resumes after it. An interrupt or exception saves the address of the instruction it displaced. Therefore a system call that loses arbitration to an interrupt runs again after the handler returns.

Top module: `priv_trap_unit`

## Requirements
- R1: While reset is held, priv is 1 (kernel; 0 means user), pc equals BOOT_PC, and sp, save_pc, save_sp, save_priv and cause are all zero.
- R2: With no event pending, pc loads npc_in only when step is 1 and sp loads sp_wdata only when sp_we is 1. Otherwise both keep their values.
- R3: A system call taken at an edge produces the following values after that edge: pc = SYS_VEC, sp = ksp_in, priv = 1, save_pc = npc_in, save_sp = the old sp and save_priv = the old priv. The cause register is left unchanged.
- R4: An external interrupt (irq_req) produces the following values after the edge: pc = TRAP_VEC, cause = 0, save_pc = the old pc, save_sp = the old sp, save_priv = the old priv, sp = ksp_in and priv = 1.
- R5: An exception (exc_req) that is not overridden by an interrupt has the same effect as R4, except that cause takes the value of exc_code. The code values are 1 for divide by zero and 2 for protection fault.
- R6: When irq_req and sys_req are both asserted at the same edge, the interrupt is taken. save_pc then holds the old pc, so the system call runs again after return.
- R7: A return-from-trap (rtt_req) in kernel mode, with no other event pending, loads pc, sp and priv from save_pc, save_sp and save_priv in one edge. The shadow registers and cause are unchanged.
- R8: A return-from-trap issued in user mode does not restore state. It is taken as an exception with cause 3 (privilege violation), with the same entry effects as R4.
- R9: Arbitration order, from highest to lowest, is interrupt, exception, system call, return-from-trap. When exc_req and sys_req are asserted together, the unit enters through TRAP_VEC with save_pc = the old pc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | An instruction retires; pc advances to npc_in |
| npc_in | input | W | Sequential next PC from fetch |
| sp_we | input | 1 | Datapath write to the stack pointer |
| sp_wdata | input | W | Stack pointer write data |
| ksp_in | input | W | Kernel stack pointer loaded on trap entry |
| sys_req | input | 1 | System-call instruction executing |
| irq_req | input | 1 | External interrupt request |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 4 | Cause code accompanying exc_req |
| rtt_req | input | 1 | Return-from-trap instruction executing |
| pc | output | W | Program counter |
| sp | output | W | Stack pointer |
| priv | output | 1 | Privilege bit, 1 = kernel |
| save_pc | output | W | Saved program counter |
| save_sp | output | W | Saved stack pointer |
| save_priv | output | 1 | Saved privilege bit |
| cause | output | 4 | Cause of the last interrupt or exception |

## Verification
Every result is registered, so each request takes effect exactly one edge after the cycle in which it is presented. The driver task presents a request at a falling edge and queues the values it predicts. The monitor takes each prediction two nanoseconds after the next rising edge and compares all seven outputs. A prediction is therefore never checked before the edge that produces it, and never after a later request has changed the outputs. The reset values are sampled directly while reset is still held.

// File: rtl/priv_trap_unit.sv
module priv_trap_unit #(
  parameter int W = 32,
  parameter logic [W-1:0] BOOT_PC  = 'h0000_0100,
  parameter logic [W-1:0] SYS_VEC  = 'h8000_0080,
  parameter logic [W-1:0] TRAP_VEC = 'h8000_0180
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] npc_in,
  input  logic         sp_we,
  input  logic [W-1:0] sp_wdata,
  input  logic [W-1:0] ksp_in,
  input  logic         sys_req,
  input  logic         irq_req,
  input  logic         exc_req,
  input  logic [3:0]   exc_code,
  input  logic         rtt_req,
  output logic [W-1:0] pc,
  output logic [W-1:0] sp,
  output logic         priv,
  output logic [W-1:0] save_pc,
  output logic [W-1:0] save_sp,
  output logic         save_priv,
  output logic [3:0]   cause
);
  localparam logic [3:0] C_IRQ  = 4'd0;
  localparam logic [3:0] C_PRIV = 4'd3;

  wire take_irq  = irq_req;
  wire take_exc  = !irq_req && exc_req;
  wire take_sys  = !irq_req && !exc_req && sys_req;
  wire rtt_ok    = !irq_req && !exc_req && !sys_req && rtt_req;
  wire priv_viol = rtt_ok && !priv;
  wire take_ret  = rtt_ok && priv;
  wire enter     = take_irq || take_exc || take_sys || priv_viol;

  wire [3:0] new_cause = take_irq ? C_IRQ : (take_exc ? exc_code : C_PRIV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= BOOT_PC;
      sp        <= '0;
      priv      <= 1'b1;
      save_pc   <= '0;
      save_sp   <= '0;
      save_priv <= 1'b0;
      cause     <= '0;
    end else if (enter) begin
      save_pc   <= take_sys ? npc_in : pc;
      save_sp   <= sp;
      save_priv <= priv;
      sp        <= ksp_in;
      priv      <= 1'b1;
      pc        <= take_sys ? SYS_VEC : TRAP_VEC;
      if (!take_sys) cause <= new_cause;
    end else if (take_ret) begin
      pc   <= save_pc;
      sp   <= save_sp;
      priv <= save_priv;
    end else begin
      if (step)  pc <= npc_in;
      if (sp_we) sp <= sp_wdata;
    end
  end
endmodule

// File: rtl/priv_trap_unit_chk.sv
module priv_trap_unit_chk #(
  parameter int W = 32,
  parameter logic [W-1:0] SYS_VEC  = 'h8000_0080,
  parameter logic [W-1:0] TRAP_VEC = 'h8000_0180
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step,
  input logic         sp_we,
  input logic         sys_req,
  input logic         irq_req,
  input logic         exc_req,
  input logic [3:0]   exc_code,
  input logic         rtt_req,
  input logic [W-1:0] pc,
  input logic [W-1:0] sp,
  input logic         priv,
  input logic [W-1:0] save_pc,
  input logic [W-1:0] save_sp,
  input logic         save_priv,
  input logic [3:0]   cause
);
  wire quiet = !sys_req && !irq_req && !exc_req && !rtt_req;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && !step && !sp_we |=> $stable(pc) && $stable(sp) && $stable(priv));

  // R3
  sys_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_req && !irq_req && !exc_req |=> pc == SYS_VEC && priv && $stable(cause)
      && save_priv == $past(priv) && save_sp == $past(sp));

  // R4
  irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> pc == TRAP_VEC && cause == 4'd0 && priv && save_pc == $past(pc));

  // R5
  exc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && !irq_req |=> pc == TRAP_VEC && cause == $past(exc_code) && save_pc == $past(pc));

  // R7
  rtt_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rtt_req && priv && !sys_req && !irq_req && !exc_req |=>
      pc == $past(save_pc) && sp == $past(save_sp) && priv == $past(save_priv) && $stable(save_pc));

  // R8
  rtt_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rtt_req && !priv && !sys_req && !irq_req && !exc_req |=>
      priv && cause == 4'd3 && pc == TRAP_VEC && !save_priv);
endmodule

bind priv_trap_unit priv_trap_unit_chk #(.W(W), .SYS_VEC(SYS_VEC), .TRAP_VEC(TRAP_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .sp_we(sp_we), .sys_req(sys_req),
  .irq_req(irq_req), .exc_req(exc_req), .exc_code(exc_code), .rtt_req(rtt_req),
  .pc(pc), .sp(sp), .priv(priv), .save_pc(save_pc), .save_sp(save_sp),
  .save_priv(save_priv), .cause(cause)
);

// File: tb/priv_trap_unit_bench.sv
`timescale 1ns/1ps
module priv_trap_unit_bench;
  localparam int W = 32;
  localparam logic [W-1:0] BOOT = 32'h0000_0100;
  localparam logic [W-1:0] SVEC = 32'h8000_0080;
  localparam logic [W-1:0] TVEC = 32'h8000_0180;

  logic clk = 0, rst_n = 0;
  logic step = 0, sp_we = 0, sys_req = 0, irq_req = 0, exc_req = 0, rtt_req = 0;
  logic [W-1:0] npc_in = '0, sp_wdata = '0, ksp_in = '0;
  logic [3:0] exc_code = '0;
  logic [W-1:0] pc, sp, save_pc, save_sp;
  logic priv, save_priv;
  logic [3:0] cause;

  always #10 clk = ~clk;

  priv_trap_unit u_priv_trap_unit (
    .clk(clk), .rst_n(rst_n), .step(step), .npc_in(npc_in), .sp_we(sp_we),
    .sp_wdata(sp_wdata), .ksp_in(ksp_in), .sys_req(sys_req), .irq_req(irq_req),
    .exc_req(exc_req), .exc_code(exc_code), .rtt_req(rtt_req), .pc(pc), .sp(sp),
    .priv(priv), .save_pc(save_pc), .save_sp(save_sp), .save_priv(save_priv), .cause(cause)
  );

  typedef struct {
    logic [W-1:0] pc, sp, epc, esp;
    logic pv, epv;
    logic [3:0] cs;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, failures = 0;
  bit done = 0;
  logic [W-1:0] m_pc = BOOT, m_sp = '0, m_epc = '0, m_esp = '0;
  logic m_pv = 1, m_epv = 0;
  logic [3:0] m_cs = '0;

  task automatic cmp(input string tag, input string f, input logic [W-1:0] act, input logic [W-1:0] ex);
    checks++;
    if (act !== ex) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, f, act, ex);
    end
  endtask

  task automatic drive(input logic st, input logic [W-1:0] npc, input logic we, input logic [W-1:0] wd,
                       input logic [W-1:0] ksp, input logic sy, input logic iq, input logic ex,
                       input logic [3:0] code, input logic rt, input string tag);
    exp_t e;
    logic ent, tsys;
    @(negedge clk);
    step = st; npc_in = npc; sp_we = we; sp_wdata = wd; ksp_in = ksp;
    sys_req = sy; irq_req = iq; exc_req = ex; exc_code = code; rtt_req = rt;
    tsys = !iq && !ex && sy;
    ent = iq || ex || sy || (rt && !m_pv);
    if (ent) begin
      m_epc = tsys ? npc : m_pc; m_esp = m_sp; m_epv = m_pv;
      m_sp = ksp; m_pv = 1; m_pc = tsys ? SVEC : TVEC;
      if (!tsys) m_cs = iq ? 4'd0 : (ex ? code : 4'd3);
    end else if (rt) begin
      m_pc = m_epc; m_sp = m_esp; m_pv = m_epv;
    end else begin
      if (st) m_pc = npc;
      if (we) m_sp = wd;
    end
    e.pc = m_pc; e.sp = m_sp; e.epc = m_epc; e.esp = m_esp;
    e.pv = m_pv; e.epv = m_epv; e.cs = m_cs; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(0, '0, 0, '0, '0, 0, 0, 0, 4'd0, 0, tag);
  endtask

  always begin
    exp_t e;
    @(posedge clk); #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      cmp(e.tag, "pc", pc, e.pc);
      cmp(e.tag, "sp", sp, e.sp);
      cmp(e.tag, "priv", W'(priv), W'(e.pv));
      cmp(e.tag, "save_pc", save_pc, e.epc);
      cmp(e.tag, "save_sp", save_sp, e.esp);
      cmp(e.tag, "save_priv", W'(save_priv), W'(e.epv));
      cmp(e.tag, "cause", W'(cause), W'(e.cs));
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1", "pc", pc, BOOT);
    cmp("R1", "priv", W'(priv), 32'd1);
    cmp("R1", "sp", sp, '0);
    cmp("R1", "cause", W'(cause), '0);
    cmp("R1", "save_pc", save_pc, '0);
    rst_n = 1;
    drive(1, 32'h104, 0, '0, '0, 0, 0, 0, 0, 0, "R2 step");
    drive(0, 32'h999, 1, 32'h1000, '0, 0, 0, 0, 0, 0, "R2 sp write no step");
    idle("R2 hold");
    drive(0, '0, 0, '0, 32'hdead, 0, 0, 0, 0, 1, "R7 kernel return");
    drive(1, 32'h200, 1, 32'h7ff0, '0, 0, 0, 0, 0, 0, "R2 user step");
    drive(0, 32'h204, 0, '0, 32'hc000, 1, 0, 0, 0, 0, "R3 syscall");
    drive(0, '0, 0, '0, '0, 0, 0, 0, 0, 1, "R7 return from syscall");
    drive(1, 32'h208, 0, '0, 32'hc100, 1, 1, 0, 0, 0, "R6 irq beats syscall");
    drive(0, '0, 0, '0, '0, 0, 0, 0, 0, 1, "R7 return from irq");
    drive(0, 32'h208, 0, '0, 32'hc200, 1, 0, 0, 0, 0, "R6 syscall reissued");
    drive(0, '0, 0, '0, '0, 0, 0, 0, 0, 1, "R7 return");
    drive(0, 32'h20c, 0, '0, 32'hc300, 0, 0, 1, 4'd1, 0, "R5 divide by zero");
    drive(0, '0, 0, '0, '0, 0, 0, 0, 0, 1, "R7 return from exc");
    drive(0, '0, 0, '0, 32'hc400, 0, 0, 0, 0, 1, "R8 user return");
    drive(0, '0, 0, '0, '0, 0, 0, 0, 0, 1, "R7 return from violation");
    drive(0, 32'h210, 0, '0, 32'hc500, 1, 0, 1, 4'd2, 0, "R9 exc beats syscall");
    drive(0, 32'h300, 0, '0, 32'hc600, 0, 1, 1, 4'd2, 0, "R4 irq beats exc");
    idle("R2 idle in kernel");
    idle("R2 final");
    @(negedge clk); @(negedge clk);
    if (q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard residue actual=%0d expected=0", q.size());
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end
endmodule